// File: doc/BRIEF.md
# Software-Refilled Tagged Translation Buffer

This block translates virtual addresses for a processor core that has no hardware page-table walker. A 64-slot, fully associative array holds translations for 4 KiB pages. Each slot is tagged with a 6-bit address-space identifier (ASID). A lookup presents the virtual address, the current ASID and a store flag. In the same cycle the block returns the physical address and one result: a hit, a miss, a modify fault, or a bypass through the unmapped window. The block does not walk page tables itself. On a miss it holds the faulting virtual page number so that a trap handler can build the entry and install it.

System software installs a slot through the entry-high inputs (page number and ASID) and the entry-low inputs (frame number, global, writable and valid). It picks the slot either through an explicit index or through a free-running replacement counter. That counter never points at the reserved low slots. A probe searches the array for the entry-high value. An invalidate command drops every slot at once. Changing the current ASID is the only thing needed on a context switch. Slots that belong to other address spaces stay loaded but do not match.

Top module: `xlate_buf`

## Requirements
- R1: For an active lookup outside the unmapped window, a valid slot whose page number equals `lk_vaddr[31:12]` and whose ASID equals `lk_asid` gives `lk_hit`=1 and `lk_paddr` = {slot frame, `lk_vaddr[11:0]`} in the same cycle.
- R2: A non-global slot whose ASID differs from `lk_asid` does not match. Changing only `lk_asid` turns a miss into a hit without any write.
- R3: A slot loaded with `el_global`=1 matches for every value of `lk_asid`.
- R4: An active mapped lookup with no matching slot gives `lk_miss`=1 in the same cycle. `miss_vpn` takes `lk_vaddr[31:12]` at the next clock edge and keeps its value in all other cycles.
- R5: Addresses with `lk_vaddr[31:29]`=3'b100 bypass the array: `lk_paddr` = `lk_vaddr` with bits 31:29 cleared, and `lk_hit`, `lk_miss`, `lk_mod_fault` and `lk_multi` all stay 0.
- R6: A store (`lk_store`=1) that matches a slot loaded with `el_writable`=0 gives `lk_mod_fault`=1 and `lk_hit`=0. A load of the same slot hits.
- R7: `wr_en` with `wr_rand`=0 writes the entry-high and entry-low inputs into slot `wr_index` at the clock edge. The new contents take effect for lookups in the following cycle.
- R8: `rand_idx` resets to 63 and steps down by one every cycle. It goes from 8 back to 63 and never shows 0..7. `wr_en` with `wr_rand`=1 writes into the slot that `rand_idx` shows before the edge.
- R9: A `probe_en` cycle registers a result at the next clock edge. For a valid slot matching `eh_vpn` and `eh_asid` (global slots ignore the ASID), the result is `probe_nf`=0 and `probe_idx` = the lowest such slot. With no such slot the result is `probe_nf`=1. The result holds until the next probe.
- R10: `inval_all` clears every valid bit at one clock edge, so no lookup matches in the following cycle. A write in the same cycle still installs its own slot.
- R11: When more than one slot matches, the lowest index supplies the frame and `lk_multi`=1.
- R12: After reset every slot is invalid, `miss_vpn`=0, `probe_idx`=0, `probe_nf`=1, `probe_multi`=0 and `rand_idx`=63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup active this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 6 | Current address-space identifier |
| lk_store | input | 1 | Lookup is for a store |
| lk_paddr | output | 32 | Physical address (meaningful on hit or bypass) |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No matching slot; software refill needed |
| lk_mod_fault | output | 1 | Store to a slot that is not writable |
| lk_multi | output | 1 | More than one slot matched |
| miss_vpn | output | 20 | Page number of the most recent miss |
| wr_en | input | 1 | Write one slot |
| wr_rand | input | 1 | 1: write the slot at rand_idx, 0: write the slot at wr_index |
| wr_index | input | 6 | Explicit slot index |
| eh_vpn | input | 20 | Entry-high page number (write and probe) |
| eh_asid | input | 6 | Entry-high ASID (write and probe) |
| el_pfn | input | 20 | Entry-low frame number |
| el_global | input | 1 | Entry-low global flag |
| el_writable | input | 1 | Entry-low writable flag |
| el_valid | input | 1 | Entry-low valid flag |
| probe_en | input | 1 | Search for the entry-high value |
| probe_idx | output | 6 | Lowest matching slot of the last probe |
| probe_nf | output | 1 | Last probe found nothing |
| probe_multi | output | 1 | Last probe found more than one slot |
| inval_all | input | 1 | Clear every valid bit |
| rand_idx | output | 6 | Replacement index |

## Verification
The hardest state to reach from the ports is a duplicate translation. Normal refill code never creates one, yet the priority rule and the multi-match flag only show in that state. The stimulus creates it on purpose by writing the same page and ASID into two slots through explicit indices. It then checks lookups and probes against that pair. It also writes one slot through the replacement counter. The bench reads `rand_idx` just before that edge and then probes to confirm that the slot shown was the one written.

// File: rtl/xb_pkg.sv
package xb_pkg;
   localparam int DEF_VA_W    = 32;
   localparam int DEF_OFS_W   = 12;
   localparam int DEF_PFN_W   = 20;
   localparam int DEF_ASID_W  = 6;
   localparam int DEF_ENTRIES = 64;
   localparam int DEF_RSVD    = 8;
   localparam int DEF_UNM_W   = 3;

   // one outcome per lookup cycle
   typedef enum logic [2:0] {
      RES_IDLE   = 3'd0,
      RES_BYPASS = 3'd1,
      RES_HIT    = 3'd2,
      RES_MISS   = 3'd3,
      RES_MODF   = 3'd4
   } xb_res_e;
endpackage

// File: rtl/xb_entry_array.sv
module xb_entry_array #(
   parameter int ENTRIES    = 64,
   parameter int VPN_W      = 20,
   parameter int PFN_W      = 20,
   parameter int ASID_W     = 6,
   parameter bit HAS_GLOBAL = 1'b1,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic [VPN_W-1:0]              wr_vpn,
   input  logic [ASID_W-1:0]             wr_asid,
   input  logic [PFN_W-1:0]              wr_pfn,
   input  logic                          wr_glob,
   input  logic                          wr_wrt,
   input  logic                          wr_vld,
   input  logic                          inval_all,
   input  logic [VPN_W-1:0]              lk_vpn,
   input  logic [ASID_W-1:0]             lk_asid,
   input  logic [VPN_W-1:0]              pr_vpn,
   input  logic [ASID_W-1:0]             pr_asid,
   output logic [ENTRIES-1:0]            lk_match,
   output logic [ENTRIES-1:0]            pr_match,
   output logic [ENTRIES-1:0][PFN_W-1:0] pfn_o,
   output logic [ENTRIES-1:0]            wrt_o
);
   logic [ENTRIES-1:0] vld_q, glob_q, wrt_q;
   logic [VPN_W-1:0]   vpn_q  [ENTRIES];
   logic [ASID_W-1:0]  asid_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q  [ENTRIES];

   // valid bits: invalidate first, a same-cycle write then claims its slot
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (inval_all) vld_q <= '0;
         if (wr_en)     vld_q[wr_idx] <= wr_vld;
      end
   end

   // payload needs no reset: it is qualified by the valid bit
   always_ff @(posedge clk) begin
      if (wr_en) begin
         vpn_q[wr_idx]  <= wr_vpn;
         asid_q[wr_idx] <= wr_asid;
         pfn_q[wr_idx]  <= wr_pfn;
         glob_q[wr_idx] <= wr_glob;
         wrt_q[wr_idx]  <= wr_wrt;
      end
   end

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic asid_ok_lk, asid_ok_pr;
      if (HAS_GLOBAL) begin : g_glob
         assign asid_ok_lk = glob_q[e] | (asid_q[e] == lk_asid);
         assign asid_ok_pr = glob_q[e] | (asid_q[e] == pr_asid);
      end else begin : g_noglob
         assign asid_ok_lk = (asid_q[e] == lk_asid);
         assign asid_ok_pr = (asid_q[e] == pr_asid);
      end
      assign lk_match[e] = vld_q[e] & (vpn_q[e] == lk_vpn) & asid_ok_lk;
      assign pr_match[e] = vld_q[e] & (vpn_q[e] == pr_vpn) & asid_ok_pr;
      assign pfn_o[e]    = pfn_q[e];
      assign wrt_o[e]    = wrt_q[e];
   end
endmodule

// File: rtl/xb_prio_enc.sv
module xb_prio_enc #(
   parameter int N     = 64,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx,
   output logic             any,
   output logic             multi
);
   // lowest set bit wins: scan downward so the last assignment is the lowest
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |req;
   // clearing the lowest set bit leaves something only if two or more were set
   assign multi = |(req & (req - {{(N-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/xb_rand_ctr.sv
module xb_rand_ctr #(
   parameter int ENTRIES = 64,
   parameter int RSVD    = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);
   localparam logic [IDX_W-1:0] LOW = IDX_W'(RSVD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idx <= TOP;
      else if (idx == LOW) idx <= TOP;
      else                 idx <= idx - 1'b1;
   end
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
   import xb_pkg::*;
#(
   parameter int VA_W       = DEF_VA_W,
   parameter int OFS_W      = DEF_OFS_W,
   parameter int PFN_W      = DEF_PFN_W,
   parameter int ASID_W     = DEF_ASID_W,
   parameter int ENTRIES    = DEF_ENTRIES,
   parameter int RSVD       = DEF_RSVD,
   parameter int UNM_W      = DEF_UNM_W,
   parameter logic [UNM_W-1:0] UNM_TAG = 3'b100,
   parameter bit HAS_GLOBAL = 1'b1,
   localparam int VPN_W     = VA_W - OFS_W,
   localparam int PA_W      = PFN_W + OFS_W,
   localparam int IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic [ASID_W-1:0] lk_asid,
   input  logic              lk_store,
   output logic [PA_W-1:0]   lk_paddr,
   output logic              lk_hit,
   output logic              lk_miss,
   output logic              lk_mod_fault,
   output logic              lk_multi,
   output logic [VPN_W-1:0]  miss_vpn,
   input  logic              wr_en,
   input  logic              wr_rand,
   input  logic [IDX_W-1:0]  wr_index,
   input  logic [VPN_W-1:0]  eh_vpn,
   input  logic [ASID_W-1:0] eh_asid,
   input  logic [PFN_W-1:0]  el_pfn,
   input  logic              el_global,
   input  logic              el_writable,
   input  logic              el_valid,
   input  logic              probe_en,
   output logic [IDX_W-1:0]  probe_idx,
   output logic              probe_nf,
   output logic              probe_multi,
   input  logic              inval_all,
   output logic [IDX_W-1:0]  rand_idx
);
   // elaboration-time parameter checks
   if (ENTRIES < 2 || ENTRIES > 256) begin : g_bad_entries
      $error("xlate_buf: ENTRIES must lie in 2..256");
   end
   if (RSVD < 0 || RSVD >= ENTRIES) begin : g_bad_rsvd
      $error("xlate_buf: RSVD must leave at least one replaceable slot");
   end
   if (OFS_W < 1 || OFS_W >= VA_W) begin : g_bad_ofs
      $error("xlate_buf: OFS_W must be smaller than VA_W");
   end
   if (UNM_W < 1 || UNM_W >= VPN_W) begin : g_bad_unm
      $error("xlate_buf: UNM_W must fit inside the page number");
   end
   if (PA_W < VA_W - UNM_W) begin : g_bad_pa
      $error("xlate_buf: physical width cannot hold the bypass window");
   end

   logic [VPN_W-1:0] lk_vpn;
   logic             in_window;
   assign lk_vpn    = lk_vaddr[VA_W-1:OFS_W];
   assign in_window = (lk_vaddr[VA_W-1 -: UNM_W] == UNM_TAG);

   logic [IDX_W-1:0] wr_slot;
   assign wr_slot = wr_rand ? rand_idx : wr_index;

   logic [ENTRIES-1:0]            lk_match, pr_match;
   logic [ENTRIES-1:0][PFN_W-1:0] slot_pfn;
   logic [ENTRIES-1:0]            slot_wrt;

   xb_entry_array #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
      .ASID_W(ASID_W), .HAS_GLOBAL(HAS_GLOBAL)
   ) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_slot),
      .wr_vpn    (eh_vpn),
      .wr_asid   (eh_asid),
      .wr_pfn    (el_pfn),
      .wr_glob   (el_global),
      .wr_wrt    (el_writable),
      .wr_vld    (el_valid),
      .inval_all (inval_all),
      .lk_vpn    (lk_vpn),
      .lk_asid   (lk_asid),
      .pr_vpn    (eh_vpn),
      .pr_asid   (eh_asid),
      .lk_match  (lk_match),
      .pr_match  (pr_match),
      .pfn_o     (slot_pfn),
      .wrt_o     (slot_wrt)
   );

   logic [IDX_W-1:0] lk_sel, pr_sel;
   logic             lk_any, lk_many, pr_any, pr_many;

   xb_prio_enc #(.N(ENTRIES)) u_lk_enc (
      .req(lk_match), .idx(lk_sel), .any(lk_any), .multi(lk_many)
   );

   xb_prio_enc #(.N(ENTRIES)) u_pr_enc (
      .req(pr_match), .idx(pr_sel), .any(pr_any), .multi(pr_many)
   );

   xb_rand_ctr #(.ENTRIES(ENTRIES), .RSVD(RSVD)) u_rand (
      .clk(clk), .rst_n(rst_n), .idx(rand_idx)
   );

   // lookup outcome
   xb_res_e res;
   always_comb begin
      if (!lk_valid)                          res = RES_IDLE;
      else if (in_window)                     res = RES_BYPASS;
      else if (!lk_any)                       res = RES_MISS;
      else if (lk_store && !slot_wrt[lk_sel]) res = RES_MODF;
      else                                    res = RES_HIT;
   end

   assign lk_hit       = (res == RES_HIT);
   assign lk_miss      = (res == RES_MISS);
   assign lk_mod_fault = (res == RES_MODF);
   assign lk_multi     = lk_valid & ~in_window & lk_many;

   always_comb begin
      if (in_window) lk_paddr = PA_W'(lk_vaddr[VA_W-UNM_W-1:0]);
      else           lk_paddr = {slot_pfn[lk_sel], lk_vaddr[OFS_W-1:0]};
   end

   // faulting page number for the refill handler
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     miss_vpn <= '0;
      else if (res == RES_MISS)       miss_vpn <= lk_vpn;
   end

   // probe result register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         probe_idx   <= '0;
         probe_nf    <= 1'b1;
         probe_multi <= 1'b0;
      end else if (probe_en) begin
         probe_idx   <= pr_sel;
         probe_nf    <= ~pr_any;
         probe_multi <= pr_many;
      end
   end
endmodule

// File: rtl/xb_checker.sv
module xb_checker #(
   parameter int VA_W    = 32,
   parameter int OFS_W   = 12,
   parameter int PA_W    = 32,
   parameter int ASID_W  = 6,
   parameter int ENTRIES = 64,
   parameter int RSVD    = 8,
   parameter int UNM_W   = 3,
   parameter logic [UNM_W-1:0] UNM_TAG = 3'b100,
   localparam int VPN_W  = VA_W - OFS_W,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lk_valid,
   input logic [VA_W-1:0]   lk_vaddr,
   input logic              lk_hit,
   input logic              lk_miss,
   input logic              lk_mod_fault,
   input logic              lk_multi,
   input logic [VPN_W-1:0]  miss_vpn,
   input logic              wr_en,
   input logic              probe_en,
   input logic [IDX_W-1:0]  probe_idx,
   input logic              probe_nf,
   input logic              inval_all,
   input logic [IDX_W-1:0]  rand_idx
);
   localparam logic [IDX_W-1:0] LOW = IDX_W'(RSVD);
   localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

   assert_miss_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_miss |=> miss_vpn == $past(lk_vaddr[VA_W-1:OFS_W]));

   assert_miss_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(lk_valid && lk_miss) |=> $stable(miss_vpn));

   assert_window_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid && lk_vaddr[VA_W-1 -: UNM_W] == UNM_TAG
      |-> !lk_miss && !lk_hit && !lk_mod_fault && !lk_multi);

   assert_rand_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rand_idx >= LOW);

   assert_rand_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rand_idx != LOW |=> rand_idx == $past(rand_idx) - 1'b1);

   assert_rand_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rand_idx == LOW |=> rand_idx == TOP);

   assert_probe_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !probe_en |=> $stable(probe_idx) && $stable(probe_nf));

   assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all && !wr_en |=> !lk_hit && !lk_mod_fault && !lk_multi);

   assert_multi_found_R11: assert property (@(posedge clk) disable iff (!rst_n)
      lk_multi |-> lk_hit || lk_mod_fault);
endmodule

bind xlate_buf xb_checker #(
   .VA_W(VA_W), .OFS_W(OFS_W), .PA_W(PA_W), .ASID_W(ASID_W),
   .ENTRIES(ENTRIES), .RSVD(RSVD), .UNM_W(UNM_W), .UNM_TAG(UNM_TAG)
) u_xb_checker (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
   .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_mod_fault(lk_mod_fault),
   .lk_multi(lk_multi), .miss_vpn(miss_vpn), .wr_en(wr_en),
   .probe_en(probe_en), .probe_idx(probe_idx), .probe_nf(probe_nf),
   .inval_all(inval_all), .rand_idx(rand_idx)
);

// File: tb/xlate_buf_bench.sv
module xlate_buf_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic [5:0]  lk_asid = '0;
   logic        lk_store = 1'b0;
   logic [31:0] lk_paddr;
   logic        lk_hit, lk_miss, lk_mod_fault, lk_multi;
   logic [19:0] miss_vpn;
   logic        wr_en = 1'b0, wr_rand = 1'b0;
   logic [5:0]  wr_index = '0;
   logic [19:0] eh_vpn = '0;
   logic [5:0]  eh_asid = '0;
   logic [19:0] el_pfn = '0;
   logic        el_global = 1'b0, el_writable = 1'b0, el_valid = 1'b0;
   logic        probe_en = 1'b0;
   logic [5:0]  probe_idx;
   logic        probe_nf, probe_multi;
   logic        inval_all = 1'b0;
   logic [5:0]  rand_idx;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   xlate_buf u_xlate_buf (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(input logic [5:0] idx, input logic rnd, input logic [19:0] vpn,
                      input logic [5:0] asid, input logic [19:0] pfn,
                      input logic g, input logic w, input logic v);
      @(negedge clk);
      wr_en = 1'b1; wr_rand = rnd; wr_index = idx; eh_vpn = vpn; eh_asid = asid;
      el_pfn = pfn; el_global = g; el_writable = w; el_valid = v;
      @(negedge clk);
      wr_en = 1'b0; wr_rand = 1'b0;
   endtask

   task automatic probe(input logic [19:0] vpn, input logic [5:0] asid);
      @(negedge clk);
      probe_en = 1'b1; eh_vpn = vpn; eh_asid = asid;
      @(negedge clk);
      probe_en = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, input logic [5:0] asid, input logic st);
      @(negedge clk);
      lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
      #1;
   endtask

   typedef struct packed {
      logic [31:0] va;
      logic [5:0]  asid;
      logic        st;
      logic        hit;
      logic        miss;
      logic        mf;
      logic        multi;
      logic [31:0] pa;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VECS [NV] = '{
      '{32'h0001_0123, 6'd5, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00AB_C123, 4'd1},  // R1 load hit
      '{32'h0001_0123, 6'd6, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         4'd2},  // R2 wrong ASID
      '{32'h0002_0FFF, 6'd9, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00DE_FFFF, 4'd3},  // R3 global
      '{32'h0002_0004, 6'd9, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,         4'd6},  // R6 store RO
      '{32'h0001_0800, 6'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h00AB_C800, 4'd1},  // R1 store hit
      '{32'h8000_1234, 6'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_1234, 4'd5},  // R5 window
      '{32'h9FFF_FFFC, 6'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1FFF_FFFC, 4'd5},  // R5 window top
      '{32'h0003_0010, 6'd7, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0123_4010, 4'd11}, // R11 dup
      '{32'h0004_0000, 6'd7, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0,         4'd4}   // R4 miss
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [19:0] last_miss;
      logic [5:0]  r, prev;
      repeat (3) @(negedge clk);
      // R12 reset state
      check("R12 rand_idx", 32'(rand_idx), 32'd63);
      check("R12 probe_nf", 32'(probe_nf), 32'd1);
      check("R12 probe_idx", 32'(probe_idx), 32'd0);
      check("R12 probe_multi", 32'(probe_multi), 32'd0);
      check("R12 miss_vpn", 32'(miss_vpn), 32'd0);
      rst_n = 1'b1;
      look(32'h0001_0123, 6'd5, 1'b0);
      check("R12 empty array misses", 32'(lk_miss), 32'd1);
      lk_valid = 1'b0;

      // install slots
      put(6'd10, 1'b0, 20'h00010, 6'd5, 20'h00ABC, 1'b0, 1'b1, 1'b1);
      put(6'd11, 1'b0, 20'h00020, 6'd0, 20'h00DEF, 1'b1, 1'b0, 1'b1);
      put(6'd12, 1'b0, 20'h00030, 6'd7, 20'h01234, 1'b0, 1'b1, 1'b1);
      put(6'd20, 1'b0, 20'h00030, 6'd7, 20'h05555, 1'b0, 1'b1, 1'b1);

      last_miss = 20'h0;
      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         look(VECS[i].va, VECS[i].asid, VECS[i].st);
         check({tag, " hit"},   32'(lk_hit),       32'(VECS[i].hit));
         check({tag, " miss"},  32'(lk_miss),      32'(VECS[i].miss));
         check({tag, " fault"}, 32'(lk_mod_fault), 32'(VECS[i].mf));
         check({tag, " multi"}, 32'(lk_multi),     32'(VECS[i].multi));
         if (!VECS[i].miss && !VECS[i].mf)
            check({tag, " paddr"}, lk_paddr, VECS[i].pa);
         if (VECS[i].miss) last_miss = VECS[i].va[31:12];
         @(negedge clk);
         lk_valid = 1'b0;
         #1;
         check({tag, " miss_vpn R4"}, 32'(miss_vpn), 32'(last_miss));
      end

      // R2 context switch: only the ASID changes
      look(32'h0001_0040, 6'd6, 1'b0);
      check("R2 other ASID misses", 32'(lk_miss), 32'd1);
      look(32'h0001_0040, 6'd5, 1'b0);
      check("R2 own ASID hits", 32'(lk_hit), 32'd1);
      look(32'h0002_0000, 6'd9, 1'b0);
      check("R6 load of RO slot hits", 32'(lk_hit), 32'd1);
      lk_valid = 1'b0;

      // R7 overwrite slot 10 and look next cycle
      put(6'd10, 1'b0, 20'h00010, 6'd5, 20'h00F0F, 1'b0, 1'b1, 1'b1);
      look(32'h0001_0001, 6'd5, 1'b0);
      check("R7 new frame", lk_paddr, 32'h00F0_F001);
      lk_valid = 1'b0;

      // R9 probes
      probe(20'h00030, 6'd7);
      check("R9 probe idx dup", 32'(probe_idx), 32'd12);
      check("R9 probe found", 32'(probe_nf), 32'd0);
      check("R11 probe multi", 32'(probe_multi), 32'd1);
      probe(20'h00020, 6'd33);
      check("R9 probe global", 32'(probe_idx), 32'd11);
      probe(20'h00050, 6'd7);
      check("R9 probe not found", 32'(probe_nf), 32'd1);
      repeat (3) @(negedge clk);
      check("R9 result held", 32'(probe_nf), 32'd1);

      // R8 replacement counter sequence and wrap
      for (int k = 0; k < 70; k++) begin
         prev = rand_idx;
         @(negedge clk);
         check("R8 rand step", 32'(rand_idx), (prev == 6'd8) ? 32'd63 : 32'(prev - 6'd1));
      end
      // R8 random write lands at the shown slot
      @(negedge clk);
      r = rand_idx;
      wr_en = 1'b1; wr_rand = 1'b1; wr_index = 6'd0; eh_vpn = 20'h00077; eh_asid = 6'd2;
      el_pfn = 20'h00099; el_global = 1'b0; el_writable = 1'b1; el_valid = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_rand = 1'b0;
      probe(20'h00077, 6'd2);
      check("R8 random slot", 32'(probe_idx), 32'(r));

      // R10 invalidate all
      @(negedge clk);
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      look(32'h0001_0001, 6'd5, 1'b0);
      check("R10 flushed slot misses", 32'(lk_miss), 32'd1);
      look(32'h0002_0001, 6'd44, 1'b0);
      check("R10 flushed global misses", 32'(lk_miss), 32'd1);
      lk_valid = 1'b0;
      probe(20'h00077, 6'd2);
      check("R10 probe empty", 32'(probe_nf), 32'd1);

      // R10 write in the same cycle as invalidate survives
      @(negedge clk);
      inval_all = 1'b1; wr_en = 1'b1; wr_rand = 1'b0; wr_index = 6'd30;
      eh_vpn = 20'h00088; eh_asid = 6'd1; el_pfn = 20'h00011;
      el_global = 1'b0; el_writable = 1'b1; el_valid = 1'b1;
      @(negedge clk);
      inval_all = 1'b0; wr_en = 1'b0;
      look(32'h0008_8ABC, 6'd1, 1'b0);
      check("R10 same-cycle write kept", lk_paddr, 32'h0001_1ABC);
      check("R10 same-cycle write hit", 32'(lk_hit), 32'd1);
      lk_valid = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule